// File: doc/BRIEF.md
# Byte Multiplier with Sequenced Sign Fix-Up

This block is the multiply unit of a small ALU. It takes a working-register operand and a second operand, both one byte wide by default. An unsigned array forms their full double-width product, which is written into two product registers: a high byte and a low byte. In signed mode the block keeps the same unsigned array and does not use a separate signed array. It latches both operands and then corrects the high byte over two more cycles. In the first of these cycles it subtracts the working operand if the second operand is negative. In the second it subtracts the second operand if the working operand is negative. The result is the two's-complement product.

An unsigned multiply finishes at the clock edge that accepts it. A signed multiply always takes three edges, because a correction cycle is spent even when its sign bit is clear. A one-cycle done pulse marks the edge after which both product registers hold the final value. When no multiply is running, software can load either product register directly, and it reads both registers on the product outputs. The block has no status-flag outputs, so it cannot disturb carry, zero, overflow or negative state.

Top module: `mulx8_core`

## Requirements
- R1: After reset, prod_hi and prod_lo are 0, and done and busy are 0.
- R2: A start accepted with signed_mode=0 loads prod_hi = bits 15:8 and prod_lo = bits 7:0 of the unsigned product of opa and opb at that same edge. done is 1 for the following cycle, and busy stays 0.
- R3: A start accepted with signed_mode=1 behaves as follows. Edge 1 loads the unsigned product. Edge 2 subtracts opa from prod_hi, modulo 256, if bit 7 of opb is 1. Edge 3 subtracts opb from prod_hi, modulo 256, if bit 7 of opa is 1. After edge 3, prod_hi:prod_lo equals the 16-bit two's-complement product and done is 1.
- R4: busy is 1 during the two cycles after a signed start is accepted. A start while busy is 1 is ignored.
- R5: The operands are captured when a start is accepted. Changes on opa and opb during a signed multiply do not alter its result.
- R6: done is 1 for exactly one cycle per accepted start. It is 1 for consecutive cycles only when an unsigned start is accepted at every edge.
- R7: While idle, with no start accepted, wr_hi=1 loads prod_hi from wr_data and wr_lo=1 loads prod_lo from wr_data. The other register is unchanged.
- R8: A write strobe during busy is ignored. A start accepted at the same edge as a write takes priority over the write.
- R9: The sign corrections never change prod_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; accepted only when busy is 0 |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opa | input | 8 | Working-register operand |
| opb | input | 8 | Second operand |
| wr_hi | input | 1 | Direct write strobe for the high product register |
| wr_lo | input | 1 | Direct write strobe for the low product register |
| wr_data | input | 8 | Data for direct writes |
| prod_hi | output | 8 | High product register |
| prod_lo | output | 8 | Low product register |
| busy | output | 1 | Signed correction in progress |
| done | output | 1 | One-cycle pulse: product registers hold the final result |

## Verification
The hardest situation to reach from the ports is the middle of a signed multiply. While the correction runs, the operand pins carry other values, a second start arrives, and write strobes are raised. All of these must be ignored, and the high byte must show the partial value left after only the first correction. On every signed operation, the bench scrambles the operands, raises start and both write strobes during the busy cycles, and samples prod_hi between the two corrections. Every unsigned operand pair is applied back to back. Random and directed signed pairs cover all four sign combinations, including the most negative operand.

// File: rtl/mulx8_pkg.sv
package mulx8_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FIX_B = 2'd1,
      PH_FIX_A = 2'd2
   } mul_phase_e;

   localparam int unsigned STYLE_OPERATOR  = 0;
   localparam int unsigned STYLE_SHIFT_ADD = 1;

endpackage

// File: rtl/mulx8_array.sv
module mulx8_array #(
   parameter int unsigned OPW   = 8,
   parameter int unsigned STYLE = 0,
   localparam int unsigned PW   = 2 * OPW
) (
   input  logic [OPW-1:0] mul_x,
   input  logic [OPW-1:0] mul_y,
   output logic [PW-1:0]  mul_p
);
   import mulx8_pkg::*;

   logic [PW-1:0] x_ext;
   assign x_ext = {{OPW{1'b0}}, mul_x};

   generate
      if (STYLE == STYLE_OPERATOR) begin : g_operator
         logic [PW-1:0] y_ext;
         assign y_ext = {{OPW{1'b0}}, mul_y};
         assign mul_p = x_ext * y_ext;
      end else begin : g_shift_add
         logic [PW-1:0] acc [OPW+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < OPW; i++) begin : g_row
            assign acc[i+1] = acc[i] + (mul_y[i] ? (x_ext << i) : {PW{1'b0}});
         end
         assign mul_p = acc[OPW];
      end
   endgenerate

endmodule

// File: rtl/mulx8_seq.sv
module mulx8_seq #(
   parameter bit SIGNED_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic signed_mode,
   output logic accept,
   output logic fix_b,
   output logic fix_a,
   output logic busy,
   output logic done
);
   import mulx8_pkg::*;

   mul_phase_e phase;
   logic       want_signed;

   generate
      if (SIGNED_SUPPORT) begin : g_signed_on
         assign want_signed = signed_mode;
      end else begin : g_signed_off
         assign want_signed = signed_mode & 1'b0;
      end
   endgenerate

   assign busy   = (phase != PH_IDLE);
   assign accept = start && !busy;
   assign fix_b  = (phase == PH_FIX_B);
   assign fix_a  = (phase == PH_FIX_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         done  <= 1'b0;
      end else begin
         done <= (accept && !want_signed) || (phase == PH_FIX_A);
         unique case (phase)
            PH_IDLE:  phase <= (accept && want_signed) ? PH_FIX_B : PH_IDLE;
            PH_FIX_B: phase <= PH_FIX_A;
            PH_FIX_A: phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end

   // R4: a signed start leads into the busy correction phases
   assert_signed_enters_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && want_signed |=> busy);

   // R4: the last correction always returns to idle, whatever start does
   assert_fix_a_returns_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fix_a |=> !busy);

   // R6: done follows only an unsigned accept or the last correction
   assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(fix_a) || $past(accept && !want_signed));

   // R6: done stays a single pulse unless another unsigned start was accepted
   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done && !(accept && !want_signed) |=> !done);

   // R4: busy is never set for longer than the two correction cycles
   assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fix_b |=> fix_a);

endmodule

// File: rtl/mulx8_prodreg.sv
module mulx8_prodreg #(
   parameter int unsigned OPW = 8,
   localparam int unsigned PW = 2 * OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [PW-1:0]  prod_in,
   input  logic           fix_b,
   input  logic           fix_a,
   input  logic [OPW-1:0] lat_a,
   input  logic [OPW-1:0] lat_b,
   input  logic           busy,
   input  logic           wr_hi,
   input  logic           wr_lo,
   input  logic [OPW-1:0] wr_data,
   output logic [OPW-1:0] reg_hi,
   output logic [OPW-1:0] reg_lo
);
   logic wr_ok;
   logic sign_a;
   logic sign_b;

   assign wr_ok  = !busy && !load;
   assign sign_a = lat_a[OPW-1];
   assign sign_b = lat_b[OPW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_hi <= '0;
      end else if (load) begin
         reg_hi <= prod_in[PW-1:OPW];
      end else if (fix_b) begin
         if (sign_b) reg_hi <= reg_hi - lat_a;
      end else if (fix_a) begin
         if (sign_a) reg_hi <= reg_hi - lat_b;
      end else if (wr_ok && wr_hi) begin
         reg_hi <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_lo <= '0;
      end else if (load) begin
         reg_lo <= prod_in[OPW-1:0];
      end else if (wr_ok && wr_lo) begin
         reg_lo <= wr_data;
      end
   end

   // R9: corrections leave the low byte untouched
   assert_lo_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_a || fix_b) |=> reg_lo == $past(reg_lo));

   // R3: second-operand sign removes the latched first operand from the high byte
   assert_fix_b_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fix_b && sign_b |=> reg_hi == OPW'($past(reg_hi) - $past(lat_a)));

   // R3: a clear sign bit leaves the high byte as it was
   assert_fix_a_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fix_a && !sign_a |=> $stable(reg_hi));

   // R8: writes during a correction do not reach the low byte
   assert_busy_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_lo |=> $stable(reg_lo));

   // R7: an idle write lands in the high byte
   assert_idle_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && wr_hi |=> reg_hi == $past(wr_data));

endmodule

// File: rtl/mulx8_core.sv
module mulx8_core #(
   parameter int unsigned OPW            = 8,
   parameter int unsigned ARRAY_STYLE    = 1,
   parameter bit          SIGNED_SUPPORT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           signed_mode,
   input  logic [OPW-1:0] opa,
   input  logic [OPW-1:0] opb,
   input  logic           wr_hi,
   input  logic           wr_lo,
   input  logic [OPW-1:0] wr_data,
   output logic [OPW-1:0] prod_hi,
   output logic [OPW-1:0] prod_lo,
   output logic           busy,
   output logic           done
);
   localparam int unsigned PW = 2 * OPW;

   generate
      if (OPW < 2 || OPW > 32) begin : g_bad_width
         $error("mulx8_core: OPW must lie in 2..32");
      end
      if (ARRAY_STYLE > 1) begin : g_bad_style
         $error("mulx8_core: ARRAY_STYLE must be 0 or 1");
      end
   endgenerate

   logic           accept;
   logic           fix_b;
   logic           fix_a;
   logic [PW-1:0]  raw_prod;
   logic [OPW-1:0] lat_a;
   logic [OPW-1:0] lat_b;

   mulx8_seq #(
      .SIGNED_SUPPORT(SIGNED_SUPPORT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .signed_mode (signed_mode),
      .accept      (accept),
      .fix_b       (fix_b),
      .fix_a       (fix_a),
      .busy        (busy),
      .done        (done)
   );

   mulx8_array #(
      .OPW   (OPW),
      .STYLE (ARRAY_STYLE)
   ) u_array (
      .mul_x (opa),
      .mul_y (opb),
      .mul_p (raw_prod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_a <= '0;
         lat_b <= '0;
      end else if (accept) begin
         lat_a <= opa;
         lat_b <= opb;
      end
   end

   mulx8_prodreg #(
      .OPW(OPW)
   ) u_prod (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .prod_in (raw_prod),
      .fix_b   (fix_b),
      .fix_a   (fix_a),
      .lat_a   (lat_a),
      .lat_b   (lat_b),
      .busy    (busy),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wr_data (wr_data),
      .reg_hi  (prod_hi),
      .reg_lo  (prod_lo)
   );

   // R5: captured operands hold still for the whole correction
   assert_operands_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lat_a) && $stable(lat_b));

   // R2: an accepted start lands the array result in the product pair
   assert_load_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> {prod_hi, prod_lo} == $past(raw_prod));

endmodule

// File: tb/mulx8_core_test.sv
`timescale 1ns/1ps
module mulx8_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       signed_mode = 1'b0;
   logic [7:0] opa = '0;
   logic [7:0] opb = '0;
   logic       wr_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] prod_hi;
   logic [7:0] prod_lo;
   logic       busy;
   logic       done;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mulx8_core uut (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
      .opa(opa), .opb(opb), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
      .prod_hi(prod_hi), .prod_lo(prod_lo), .busy(busy), .done(done)
   );

   function automatic logic [15:0] ref_unsigned(input logic [7:0] a, input logic [7:0] b);
      return 16'(a) * 16'(b);
   endfunction

   function automatic logic [15:0] ref_signed(input logic [7:0] a, input logic [7:0] b);
      int p;
      p = int'($signed(a)) * int'($signed(b));
      return p[15:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at a negedge with the result checked
   task automatic mul_unsigned(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] e;
      e = ref_unsigned(a, b);
      opa = a; opb = b; signed_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      check("R2 unsigned product/done/busy", {prod_hi, prod_lo, 6'd0, done, busy}, {e, 6'd0, 1'b1, 1'b0});
   endtask

   task automatic mul_signed(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] eu;
      logic [15:0] es;
      logic [7:0]  mid;
      eu  = ref_unsigned(a, b);
      es  = ref_signed(a, b);
      mid = eu[15:8] - (b[7] ? a : 8'd0);
      opa = a; opb = b; signed_mode = 1'b1; start = 1'b1;
      @(negedge clk);
      check("R4 busy after signed start", {done, busy}, 2'b01);
      check("R3 high byte after load", prod_hi, eu[15:8]);
      // disturb: new operands, a second start and both writes while busy
      opa = $urandom; opb = $urandom; signed_mode = $urandom;
      wr_hi = 1'b1; wr_lo = 1'b1; wr_data = $urandom;
      @(negedge clk);
      check("R3 high byte after second-operand fix", prod_hi, mid);
      check("R8 low byte ignores busy write", prod_lo, eu[7:0]);
      check("R4 still busy, no done", {done, busy}, 2'b01);
      @(negedge clk);
      start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
      check("R3 R5 signed product after third edge", {prod_hi, prod_lo}, es);
      check("R6 done at completion, busy clear", {done, busy}, 2'b10);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      check("R1 reset state", {prod_hi, prod_lo, 6'd0, done, busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset release", {prod_hi, prod_lo, 6'd0, done, busy}, 32'd0);

      // R7: direct writes while idle
      wr_hi = 1'b1; wr_data = 8'hA5;
      @(negedge clk);
      wr_hi = 1'b0;
      check("R7 write high", {prod_hi, prod_lo}, 16'hA500);
      wr_lo = 1'b1; wr_data = 8'h3C;
      @(negedge clk);
      wr_lo = 1'b0;
      check("R7 write low keeps high", {prod_hi, prod_lo}, 16'hA53C);
      wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 8'h5A;
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0;
      check("R7 write both", {prod_hi, prod_lo}, 16'h5A5A);
      check("R6 no done from writes", done, 1'b0);

      // R8: start beats a simultaneous write
      wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 8'h11;
      mul_unsigned(8'h0F, 8'h10);
      wr_hi = 1'b0; wr_lo = 1'b0; start = 1'b0;
      @(negedge clk);
      check("R6 done drops after single start", done, 1'b0);
      check("R8 start priority product kept", {prod_hi, prod_lo}, 16'h00F0);

      // directed signed corners across all sign combinations
      mul_signed(8'h80, 8'h80);
      check("R6 done one cycle only", done, 1'b1);
      @(negedge clk);
      check("R6 done gone after signed pulse", done, 1'b0);
      mul_signed(8'hFF, 8'hFF);
      mul_signed(8'h80, 8'h7F);
      mul_signed(8'h7F, 8'h80);
      mul_signed(8'h7F, 8'h7F);
      mul_signed(8'h80, 8'hFF);
      mul_signed(8'h01, 8'hFF);
      mul_signed(8'h00, 8'h80);
      mul_signed(8'h9C, 8'h00);

      // R2: every unsigned pair, back to back
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            mul_unsigned(8'(a), 8'(b));
         end
      end
      start = 1'b0;
      @(negedge clk);
      check("R6 done clears after unsigned stream", done, 1'b0);

      // R3 R5: random signed pairs with mid-run disturbance
      for (int k = 0; k < 20000; k++) begin
         mul_signed(8'($urandom), 8'($urandom));
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule